// File: doc/BRIEF.md
# Thread Block Admission Controller

This block decides whether a launch request for one thread block may be placed on a single multiprocessor. A request names the number of threads the block needs and the number of shared-memory bytes it needs. Three budgets limit admission at the same moment: free block slots, resident threads and shared-memory bytes. Whichever budget runs short first holds the request back. A block is admitted whole or not at all.

The requester keeps `req_valid` high with stable fields until `req_ready` is seen high at a clock edge. A block that is taken receives a slot ID, and the block's warp count is reported one cycle after the edge that accepts it. When the block finishes, the execution side pulses `done_valid` with that slot ID. The slot's threads and bytes then return to the pools. A release and a launch on the same edge are resolved with the release first, so the freed slot and budget can serve that launch.

Top module: `blk_admit_ctrl`

## Requirements
- R1: Synchronous active-high reset leaves no slot busy, all three usage counts at zero and `grant_valid` low.
- R2: A request is accepted on an edge where `req_valid` and `req_ready` are both high. On that edge the thread count grows by the exact requested threads, the byte count by the exact requested bytes and the block count by one.
- R3: At most MAX_BLOCKS (8) blocks are resident. With every slot busy and no release in the same cycle, `req_ready` is low.
- R4: Resident threads never exceed MAX_THREADS (768). A request for more than MAX_THREADS threads (for example 1024) is never ready. A request that fills the thread budget exactly is ready.
- R5: Resident shared memory never exceeds SMEM_BYTES (16384). A request whose bytes exceed the bytes left is not ready. A request that uses them up exactly is ready.
- R6: A request for zero threads is never ready.
- R7: One cycle after an accepting edge, `grant_valid` is high for exactly one cycle. In that cycle `grant_slot` is the lowest-numbered slot free on the accepting edge, and `grant_warps` is the thread count divided by 32, rounded up.
- R8: A `done_valid` pulse for a busy slot returns that slot's threads, bytes and slot on the same edge. A pulse for a slot that is not busy leaves all counts unchanged.
- R9: When a release and a launch fall on the same edge, the release is applied first. The launch may use the slot and budget just freed.
- R10: A request that is not ready changes no count and raises no grant. It remains pending, and it is accepted once a release makes room.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Launch request present |
| req_ready | output | 1 | Request fits all three budgets in this cycle |
| req_threads | input | REQ_THR_W (11) | Threads asked for |
| req_smem | input | REQ_SMEM_W (15) | Shared-memory bytes asked for |
| grant_valid | output | 1 | One-cycle pulse after an accepted request |
| grant_slot | output | SLOT_W (3) | Slot given to the accepted block |
| grant_warps | output | WARP_W (5) | Warps created for the accepted block |
| done_valid | input | 1 | Block completion pulse |
| done_slot | input | SLOT_W (3) | Slot of the completing block |
| threads_in_use | output | THR_W (10) | Resident thread count |
| smem_in_use | output | SMEM_W (15) | Resident shared-memory bytes |
| blocks_in_use | output | BLK_W (4) | Resident block count |

## Verification
The hardest case to reach is a completion and a launch on the same edge while a budget is exactly at its limit. In that case the launch fits only because the release counts first. Directed stimulus fills all eight slots and then pulses a completion together with a pending request. Other directed cases fill the thread budget and the byte budget exactly. Random traffic weighted toward large requests then produces many full-budget cycles with a release and a launch together. A bench model applies the release before the allocation and predicts ready, slot, warps and counts for every cycle.

// File: rtl/blk_admit_pkg.sv
package blk_admit_pkg;
  function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/blk_slot_table.sv
module blk_slot_table #(
  parameter int NSLOT  = 8,
  parameter int SLOT_W = 3,
  parameter int THR_W  = 10,
  parameter int SMEM_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_en,
  input  logic [SLOT_W-1:0] alloc_slot,
  input  logic [THR_W-1:0]  alloc_thr,
  input  logic [SMEM_W-1:0] alloc_smem,
  input  logic              rel_en,
  input  logic [SLOT_W-1:0] rel_slot,
  output logic [NSLOT-1:0]  busy,
  output logic              rel_hit,
  output logic [THR_W-1:0]  rel_thr,
  output logic [SMEM_W-1:0] rel_smem
);
  logic [THR_W-1:0]  thr_mem  [NSLOT];
  logic [SMEM_W-1:0] smem_mem [NSLOT];

  always_ff @(posedge clk) begin
    if (alloc_en) begin
      thr_mem[alloc_slot]  <= alloc_thr;
      smem_mem[alloc_slot] <= alloc_smem;
    end
  end

  assign rel_hit  = rel_en && (32'(rel_slot) < NSLOT) && busy[rel_slot];
  assign rel_thr  = rel_hit ? thr_mem[rel_slot]  : '0;
  assign rel_smem = rel_hit ? smem_mem[rel_slot] : '0;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic occ_q;
    always_ff @(posedge clk) begin
      if (rst)                                          occ_q <= 1'b0;
      else if (alloc_en && alloc_slot == SLOT_W'(i))    occ_q <= 1'b1;
      else if (rel_hit && rel_slot == SLOT_W'(i))       occ_q <= 1'b0;
    end
    assign busy[i] = occ_q;
  end
endmodule

// File: rtl/blk_free_pick.sv
module blk_free_pick #(
  parameter int NSLOT  = 8,
  parameter int SLOT_W = 3
) (
  input  logic [NSLOT-1:0]  busy,
  input  logic              rel_hit,
  input  logic [SLOT_W-1:0] rel_slot,
  output logic              any_free,
  output logic [SLOT_W-1:0] pick
);
  logic [NSLOT-1:0] free_m;

  for (genvar i = 0; i < NSLOT; i++) begin : g_free
    assign free_m[i] = !busy[i] || (rel_hit && rel_slot == SLOT_W'(i));
  end

  always_comb begin
    pick = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (free_m[i]) pick = SLOT_W'(i);
    end
  end

  assign any_free = |free_m;
endmodule

// File: rtl/blk_budget_acct.sv
module blk_budget_acct #(
  parameter int MAX_THREADS = 768,
  parameter int SMEM_BYTES  = 16384,
  parameter int REQ_THR_W   = 11,
  parameter int REQ_SMEM_W  = 15,
  parameter int THR_W       = 10,
  parameter int SMEM_W      = 15,
  parameter int BLK_W       = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  alloc_en,
  input  logic [REQ_THR_W-1:0]  req_thr,
  input  logic [REQ_SMEM_W-1:0] req_smem,
  input  logic                  rel_hit,
  input  logic [THR_W-1:0]      rel_thr,
  input  logic [SMEM_W-1:0]     rel_smem,
  output logic [THR_W-1:0]      thr_used,
  output logic [SMEM_W-1:0]     smem_used,
  output logic [BLK_W-1:0]      blk_used,
  output logic                  fit_thr,
  output logic                  fit_smem
);
  logic [31:0] thr_after, smem_after, req_thr_w, req_smem_w;

  assign req_thr_w  = 32'(req_thr);
  assign req_smem_w = 32'(req_smem);
  assign thr_after  = 32'(thr_used)  - 32'(rel_thr);
  assign smem_after = 32'(smem_used) - 32'(rel_smem);

  assign fit_thr  = (req_thr_w != 0) && (req_thr_w <= 32'(MAX_THREADS) - thr_after);
  assign fit_smem = req_smem_w <= 32'(SMEM_BYTES) - smem_after;

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_used  <= '0;
      smem_used <= '0;
      blk_used  <= '0;
    end else begin
      thr_used  <= THR_W'(thr_after + (alloc_en ? req_thr_w : 32'd0));
      smem_used <= SMEM_W'(smem_after + (alloc_en ? req_smem_w : 32'd0));
      blk_used  <= BLK_W'(32'(blk_used) - (rel_hit ? 32'd1 : 32'd0) + (alloc_en ? 32'd1 : 32'd0));
    end
  end
endmodule

// File: rtl/blk_admit_ctrl.sv
module blk_admit_ctrl #(
  parameter int MAX_BLOCKS  = 8,
  parameter int MAX_THREADS = 768,
  parameter int SMEM_BYTES  = 16384,
  parameter int WARP_SIZE   = 32,
  parameter int REQ_THR_W   = $clog2(MAX_THREADS) + 1,
  parameter int REQ_SMEM_W  = $clog2(SMEM_BYTES + 1),
  localparam int SLOT_W     = (MAX_BLOCKS > 1) ? $clog2(MAX_BLOCKS) : 1,
  localparam int THR_W      = $clog2(MAX_THREADS + 1),
  localparam int SMEM_W     = $clog2(SMEM_BYTES + 1),
  localparam int BLK_W      = $clog2(MAX_BLOCKS + 1),
  localparam int WARP_W     = $clog2(MAX_THREADS / WARP_SIZE + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [REQ_THR_W-1:0]  req_threads,
  input  logic [REQ_SMEM_W-1:0] req_smem,
  output logic                  grant_valid,
  output logic [SLOT_W-1:0]     grant_slot,
  output logic [WARP_W-1:0]     grant_warps,
  input  logic                  done_valid,
  input  logic [SLOT_W-1:0]     done_slot,
  output logic [THR_W-1:0]      threads_in_use,
  output logic [SMEM_W-1:0]     smem_in_use,
  output logic [BLK_W-1:0]      blocks_in_use
);
  import blk_admit_pkg::*;

  logic [MAX_BLOCKS-1:0] busy;
  logic                  rel_hit, any_free, fit_thr, fit_smem, accept;
  logic [THR_W-1:0]      rel_thr;
  logic [SMEM_W-1:0]     rel_smem;
  logic [SLOT_W-1:0]     pick;

  blk_slot_table #(
    .NSLOT(MAX_BLOCKS), .SLOT_W(SLOT_W), .THR_W(THR_W), .SMEM_W(SMEM_W)
  ) u_table (
    .clk(clk), .rst(rst),
    .alloc_en(accept), .alloc_slot(pick),
    .alloc_thr(THR_W'(req_threads)), .alloc_smem(SMEM_W'(req_smem)),
    .rel_en(done_valid), .rel_slot(done_slot),
    .busy(busy), .rel_hit(rel_hit), .rel_thr(rel_thr), .rel_smem(rel_smem)
  );

  blk_free_pick #(.NSLOT(MAX_BLOCKS), .SLOT_W(SLOT_W)) u_pick (
    .busy(busy), .rel_hit(rel_hit), .rel_slot(done_slot),
    .any_free(any_free), .pick(pick)
  );

  blk_budget_acct #(
    .MAX_THREADS(MAX_THREADS), .SMEM_BYTES(SMEM_BYTES),
    .REQ_THR_W(REQ_THR_W), .REQ_SMEM_W(REQ_SMEM_W),
    .THR_W(THR_W), .SMEM_W(SMEM_W), .BLK_W(BLK_W)
  ) u_acct (
    .clk(clk), .rst(rst), .alloc_en(accept),
    .req_thr(req_threads), .req_smem(req_smem),
    .rel_hit(rel_hit), .rel_thr(rel_thr), .rel_smem(rel_smem),
    .thr_used(threads_in_use), .smem_used(smem_in_use), .blk_used(blocks_in_use),
    .fit_thr(fit_thr), .fit_smem(fit_smem)
  );

  assign req_ready = any_free && fit_thr && fit_smem;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_valid <= 1'b0;
      grant_slot  <= '0;
      grant_warps <= '0;
    end else begin
      grant_valid <= accept;
      if (accept) begin
        grant_slot  <= pick;
        grant_warps <= WARP_W'(ceil_div(32'(req_threads), WARP_SIZE));
      end
    end
  end
endmodule

// File: rtl/blk_admit_chk.sv
module blk_admit_chk #(
  parameter int MAX_BLOCKS  = 8,
  parameter int MAX_THREADS = 768,
  parameter int SMEM_BYTES  = 16384,
  parameter int WARP_SIZE   = 32,
  parameter int REQ_THR_W   = 11,
  parameter int REQ_SMEM_W  = 15,
  parameter int WARP_W      = 5,
  parameter int THR_W       = 10,
  parameter int SMEM_W      = 15,
  parameter int BLK_W       = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic [REQ_THR_W-1:0]  req_threads,
  input logic                  grant_valid,
  input logic [WARP_W-1:0]     grant_warps,
  input logic                  done_valid,
  input logic [THR_W-1:0]      threads_in_use,
  input logic [SMEM_W-1:0]     smem_in_use,
  input logic [BLK_W-1:0]      blocks_in_use
);
  AST_BLK_BOUND: assert property (@(posedge clk) disable iff (rst)
    32'(blocks_in_use) <= MAX_BLOCKS); // R3
  AST_THR_BOUND: assert property (@(posedge clk) disable iff (rst)
    32'(threads_in_use) <= MAX_THREADS); // R4
  AST_SMEM_BOUND: assert property (@(posedge clk) disable iff (rst)
    32'(smem_in_use) <= SMEM_BYTES); // R5
  AST_OVERSIZE_REFUSED: assert property (@(posedge clk) disable iff (rst)
    (32'(req_threads) > MAX_THREADS) |-> !req_ready); // R4
  AST_ZERO_REFUSED: assert property (@(posedge clk) disable iff (rst)
    (req_threads == '0) |-> !req_ready); // R6
  AST_GRANT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> grant_valid); // R7
  AST_NO_SPURIOUS_GRANT: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> !grant_valid); // R7
  AST_WARPS_COVER: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=>
      (32'(grant_warps) * WARP_SIZE >= 32'($past(req_threads))) &&
      (32'(grant_warps) * WARP_SIZE < 32'($past(req_threads)) + WARP_SIZE)); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!(req_valid && req_ready) && !done_valid) |=>
      $stable(threads_in_use) && $stable(smem_in_use) && $stable(blocks_in_use)); // R10
endmodule

bind blk_admit_ctrl blk_admit_chk #(
  .MAX_BLOCKS(MAX_BLOCKS), .MAX_THREADS(MAX_THREADS), .SMEM_BYTES(SMEM_BYTES),
  .WARP_SIZE(WARP_SIZE), .REQ_THR_W(REQ_THR_W), .REQ_SMEM_W(REQ_SMEM_W),
  .WARP_W(WARP_W), .THR_W(THR_W), .SMEM_W(SMEM_W), .BLK_W(BLK_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_threads(req_threads), .grant_valid(grant_valid), .grant_warps(grant_warps),
  .done_valid(done_valid), .threads_in_use(threads_in_use),
  .smem_in_use(smem_in_use), .blocks_in_use(blocks_in_use)
);

// File: tb/blk_admit_ctrl_test.sv
module blk_admit_ctrl_test;
  localparam int NB = 8, MT = 768, MS = 16384, WS = 32;

  logic        clk = 1'b0, rst = 1'b1;
  logic        req_valid = 1'b0, done_valid = 1'b0;
  logic [10:0] req_threads = '0;
  logic [14:0] req_smem = '0;
  logic [2:0]  done_slot = '0;
  logic        req_ready, grant_valid;
  logic [2:0]  grant_slot;
  logic [4:0]  grant_warps;
  logic [9:0]  threads_in_use;
  logic [14:0] smem_in_use;
  logic [3:0]  blocks_in_use;

  int n_chk = 0, n_fail = 0;
  bit m_busy [NB];
  int m_thr [NB], m_smem [NB];
  int m_t = 0, m_s = 0, m_b = 0;
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  blk_admit_ctrl uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_threads(req_threads), .req_smem(req_smem),
    .grant_valid(grant_valid), .grant_slot(grant_slot), .grant_warps(grant_warps),
    .done_valid(done_valid), .done_slot(done_slot),
    .threads_in_use(threads_in_use), .smem_in_use(smem_in_use),
    .blocks_in_use(blocks_in_use)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit rel_hits(input bit dv, input int ds);
    return dv && m_busy[ds];
  endfunction

  function automatic int pick_free(input bit dv, input int ds);
    for (int i = 0; i < NB; i++)
      if (!m_busy[i] || (rel_hits(dv, ds) && i == ds)) return i;
    return -1;
  endfunction

  function automatic bit exp_ready(input int thr, input int sm, input bit dv, input int ds);
    int t, s;
    t = m_t - (rel_hits(dv, ds) ? m_thr[ds] : 0);
    s = m_s - (rel_hits(dv, ds) ? m_smem[ds] : 0);
    return thr > 0 && thr <= MT && t + thr <= MT && s + sm <= MS && pick_free(dv, ds) >= 0;
  endfunction

  // One cycle: drive, check ready, clock, update model, check registered outputs.
  task automatic step(input bit v, input int thr, input int sm, input bit dv,
                      input int ds, input string tag);
    bit rdy, acc;
    int slot;
    @(negedge clk);
    req_valid = v; req_threads = 11'(thr); req_smem = 15'(sm);
    done_valid = dv; done_slot = 3'(ds);
    #2;
    rdy  = exp_ready(thr, sm, dv, ds);
    slot = pick_free(dv, ds);
    chk(req_ready == rdy, {tag, " ready"}, int'(req_ready), int'(rdy));
    acc = v && rdy;
    @(posedge clk);
    if (rel_hits(dv, ds)) begin  // R9: release before allocation
      m_busy[ds] = 1'b0; m_t -= m_thr[ds]; m_s -= m_smem[ds]; m_b--;
    end
    if (acc) begin
      m_busy[slot] = 1'b1; m_thr[slot] = thr; m_smem[slot] = sm;
      m_t += thr; m_s += sm; m_b++;
    end
    #2;
    chk(grant_valid == acc, "R7 grant_valid", int'(grant_valid), int'(acc));
    if (acc) begin
      chk(int'(grant_slot) == slot, "R7 grant_slot", int'(grant_slot), slot);
      chk(int'(grant_warps) == (thr + WS - 1) / WS, "R7 grant_warps",
          int'(grant_warps), (thr + WS - 1) / WS);
    end
    chk(int'(threads_in_use) == m_t, "R2 R8 threads", int'(threads_in_use), m_t);
    chk(int'(smem_in_use) == m_s, "R2 R8 smem", int'(smem_in_use), m_s);
    chk(int'(blocks_in_use) == m_b, "R2 R8 blocks", int'(blocks_in_use), m_b);
  endtask

  task automatic drain();
    for (int i = 0; i < NB; i++) step(1'b0, 0, 0, 1'b1, i, "R8");
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end

  initial begin
    int thr, sm;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #2;
    // R1 reset state
    chk(grant_valid == 1'b0, "R1 grant", int'(grant_valid), 0);
    chk(threads_in_use == '0, "R1 threads", int'(threads_in_use), 0);
    chk(smem_in_use == '0, "R1 smem", int'(smem_in_use), 0);
    chk(blocks_in_use == '0, "R1 blocks", int'(blocks_in_use), 0);

    step(1'b1, 0, 0, 1'b0, 0, "R6");        // zero threads refused
    step(1'b1, 1024, 0, 1'b0, 0, "R4");     // oversize refused
    step(1'b1, 769, 0, 1'b0, 0, "R4");
    for (int i = 0; i < NB; i++) step(1'b1, 33, 100, 1'b0, 0, "R3");
    step(1'b1, 32, 0, 1'b0, 0, "R3");       // all slots busy
    step(1'b1, 32, 0, 1'b0, 0, "R10");      // still pending, nothing changes
    step(1'b1, 32, 0, 1'b1, 3, "R9");       // release and launch together
    drain();
    step(1'b0, 0, 0, 1'b1, 5, "R8");        // release of empty slot ignored
    step(1'b1, 768, 0, 1'b0, 0, "R4");      // exact thread fill
    step(1'b1, 1, 0, 1'b0, 0, "R4");
    step(1'b1, 32, 0, 1'b1, 0, "R9");       // thread budget freed same edge
    drain();
    step(1'b1, 32, 16384, 1'b0, 0, "R5");   // exact byte fill
    step(1'b1, 32, 1, 1'b0, 0, "R5");
    step(1'b1, 32, 20000, 1'b0, 0, "R5");
    step(1'b1, 32, 8000, 1'b1, 0, "R9");
    drain();

    for (int n = 0; n < 4000; n++) begin
      case ($urandom_range(0, 3))
        0: thr = $urandom_range(1, 64);
        1: thr = 32 * $urandom_range(1, 8);
        2: thr = $urandom_range(100, 400);
        default: thr = $urandom_range(0, 1100);
      endcase
      sm = ($urandom_range(0, 4) == 0) ? $urandom_range(0, 17000) : $urandom_range(0, 5000);
      step($urandom_range(0, 3) != 0, thr, sm, $urandom_range(0, 2) == 0,
           $urandom_range(0, NB - 1), "R2");
    end

    done_flag = 1'b1;
    finish_run();
  end
endmodule